// File: doc/BRIEF.md
# Mapped Store Unit

This block is the data store of a small 8-bit register datapath. Each cycle it takes two 8-bit operands from the register read ports. The A operand supplies the data. The B operand supplies the address. When the register file is not writing back, the cycle is a store. The store goes to a 128-word by 8-bit array, or to a separate output register, and bit 7 of the address picks which one.

The output register is shown as two hexadecimal digits on active-low seven-segment outputs. The block also returns combinational read data for the register write-back path. A read with address bit 7 clear returns the selected array word. A read with bit 7 set returns the output register, so software can read back what it displayed.

Top module: `mapped_store`

## Requirements
- R1: A synchronous active-low reset clears the output register to 0x00 on the rising clock edge. The array contents are not cleared.
- R2: On a rising edge with `rf_we` low and `opnd_b[7]` = 0, the array word at index `opnd_b[6:0]` takes the value of `opnd_a`.
- R3: On a rising edge with `rf_we` low and `opnd_b[7]` = 1, the output register takes `opnd_a`, and no array word changes.
- R4: While `rf_we` is high, no store takes place, so both the array and the output register keep their values.
- R5: When `opnd_b[7]` = 0, `rd_data` combinationally equals the array word at index `opnd_b[6:0]`.
- R6: When `opnd_b[7]` = 1, `rd_data` combinationally equals the current output register value.
- R7: `seg_lo_n` shows output register bits 3:0 and `seg_hi_n` shows bits 7:4. Both are active-low. Bit 0 drives segment a, and bits 1 to 6 drive segments b, c, d, e, f and g in that order.
- R8: All sixteen nibble values are decoded. In active-high gfedcba form they are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_we | input | 1 | Register-file write enable; when high, the store is suppressed |
| opnd_a | input | 8 | Store data |
| opnd_b | input | 8 | Address; bit 7 selects the output register |
| rd_data | output | 8 | Combinational read data for write-back |
| seg_lo_n | output | 7 | Active-low segments of the low-nibble digit |
| seg_hi_n | output | 7 | Active-low segments of the high-nibble digit |

## Verification
The bench targets the two ends of each address half: indices 0x00 and 0x7F, and the mapped addresses 0x80 and 0xFF. It checks that a mapped store leaves the array word at the same low seven bits untouched. A decoder that ignored bit 7 would fail here, because it would overwrite that word. The bench also drives stores with the write enable high and then reads back. A design that stored during write-back would corrupt the array or the display. A stepped sweep sets the output register to different high and low nibbles, which exposes a digit swap or a wrong segment pattern. Constrained random traffic then mixes all of these cases.

// File: rtl/mapped_store_pkg.sv
// Package: shared widths for the mapped store unit.
// Assumes the data width is a whole number of hexadecimal nibbles.
package mapped_store_pkg;
    parameter int DATA_W = 8;
    parameter int SEG_W  = 7;
    localparam int IDX_W  = DATA_W - 1;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int N_DIG  = DATA_W / 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEG_W-1:0]  seg_t;
endpackage

// File: rtl/mapped_store_decode.sv
// Module: address decode. Splits one store request into an array write
// or an output-register load, based on the top address bit.
// Assumes rf_we high means the register file owns this cycle.
module mapped_store_decode #(
    parameter int DATA_W = 8
) (
    input  logic              rf_we,
    input  logic [DATA_W-1:0] addr,
    output logic              mem_we,
    output logic              out_we,
    output logic              rd_sel_out
);
    logic store_cyc;

    // Purpose: derive the store strobes and the read source select.
    always_comb begin
        store_cyc  = ~rf_we;
        mem_we     = store_cyc & ~addr[DATA_W-1];
        out_we     = store_cyc &  addr[DATA_W-1];
        rd_sel_out = addr[DATA_W-1];
    end
endmodule

// File: rtl/mapped_store_array.sv
// Module: storage array with a synchronous write and a combinational read.
// Assumes the contents do not need a reset.
module mapped_store_array #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Purpose: write the addressed word on the rising edge.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
    end

    // Purpose: return the addressed word with no clock delay.
    always_comb begin
        rdata = cells[idx];
    end
endmodule

// File: rtl/mapped_store_outreg.sv
// Module: output register that drives the display.
// Assumes reset is synchronous and active-low.
module mapped_store_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Purpose: clear on reset, otherwise capture din when load is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/mapped_store_hexseg.sv
// Module: nibble to seven-segment decoder, with bit 0 as segment a and
// bit 6 as segment g. ACTIVE_LOW selects the output polarity.
module mapped_store_hexseg #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [3:0] nib,
    output logic [6:0] seg
);
    logic [6:0] lit;

    // Purpose: look up the lit segments for the nibble (active-high).
    always_comb begin
        unique case (nib)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
    end

    // Purpose: apply the chosen output polarity.
    generate
        if (ACTIVE_LOW) begin : g_low
            assign seg = ~lit;
        end else begin : g_high
            assign seg = lit;
        end
    endgenerate
endmodule

// File: rtl/mapped_store.sv
// Module: mapped store unit (top). A store goes to the array, or to the
// display register when address bit 7 is set. The read data follows the
// same split. Assumes a store is allowed only while rf_we is low.
module mapped_store
    import mapped_store_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_we,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEG_W-1:0]  seg_lo_n,
    output logic [SEG_W-1:0]  seg_hi_n
);
    logic  mem_we;
    logic  out_we;
    logic  rd_sel_out;
    word_t mem_rd;
    word_t out_q;
    seg_t  digit_seg [N_DIG];

    mapped_store_decode #(.DATA_W(DATA_W)) u_decode (
        .rf_we      (rf_we),
        .addr       (opnd_b),
        .mem_we     (mem_we),
        .out_we     (out_we),
        .rd_sel_out (rd_sel_out)
    );

    mapped_store_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .idx   (opnd_b[IDX_W-1:0]),
        .wdata (opnd_a),
        .rdata (mem_rd)
    );

    mapped_store_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (out_we),
        .din   (opnd_a),
        .q     (out_q)
    );

    // Purpose: one decoder for each nibble of the output register.
    generate
        for (genvar d = 0; d < N_DIG; d++) begin : g_dig
            mapped_store_hexseg #(.ACTIVE_LOW(1'b1)) u_hex (
                .nib (out_q[4*d +: 4]),
                .seg (digit_seg[d])
            );
        end
    endgenerate

    // Purpose: choose the read-back source and drive the two digits.
    always_comb begin
        rd_data  = rd_sel_out ? out_q : mem_rd;
        seg_lo_n = digit_seg[0];
        seg_hi_n = digit_seg[N_DIG-1];
    end
endmodule

// File: rtl/mapped_store_chk.sv
// Module: assertion checker bound to the mapped store top.
module mapped_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rf_we,
    input logic [7:0] opnd_a,
    input logic [7:0] opnd_b,
    input logic [7:0] rd_data,
    input logic [6:0] seg_lo_n,
    input logic [6:0] seg_hi_n,
    input logic [7:0] out_q
);
    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rf_we && opnd_b[7]) |=> (out_q == $past(opnd_a)));                // R3
    AST_OUT_HOLD_WE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> $stable(out_q));                                        // R4
    AST_RD_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_b[7] |-> (rd_data == out_q));                                // R6
    AST_SEG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(out_q) |-> ($stable(seg_lo_n) && $stable(seg_hi_n)));     // R7
    AST_MEM_HOLD_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $stable(opnd_b) && !opnd_b[7]) |=>
        (!$stable(opnd_b) || rd_data == $past(rd_data)));                 // R4
endmodule

bind mapped_store mapped_store_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_we    (rf_we),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .rd_data  (rd_data),
    .seg_lo_n (seg_lo_n),
    .seg_hi_n (seg_hi_n),
    .out_q    (out_q)
);

// File: tb/mapped_store_bench.sv
module mapped_store_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rf_we = 1'b1;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [7:0] rd_data;
    logic [6:0] seg_lo_n;
    logic [6:0] seg_hi_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_mem [128];
    bit         m_ok  [128];
    logic [7:0] m_out = 8'h00;

    mapped_store u_mapped_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rf_we    (rf_we),
        .opnd_a   (opa),
        .opnd_b   (opb),
        .rd_data  (rd_data),
        .seg_lo_n (seg_lo_n),
        .seg_hi_n (seg_hi_n)
    );

    always #5 clk = ~clk;

    // Expected active-low pattern for a nibble (R8 table).
    function automatic logic [6:0] exp_seg(input logic [3:0] v);
        logic [6:0] on;
        case (v)
            4'h0: on = 7'h3F;  4'h1: on = 7'h06;  4'h2: on = 7'h5B;
            4'h3: on = 7'h4F;  4'h4: on = 7'h66;  4'h5: on = 7'h6D;
            4'h6: on = 7'h7D;  4'h7: on = 7'h07;  4'h8: on = 7'h7F;
            4'h9: on = 7'h6F;  4'hA: on = 7'h77;  4'hB: on = 7'h7C;
            4'hC: on = 7'h39;  4'hD: on = 7'h5E;  4'hE: on = 7'h79;
            default: on = 7'h71;
        endcase
        return ~on;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the combinational outputs with the model (R5, R6, R7).
    task automatic look(input string req);
        if (opb[7]) chk({req, "/R6 read mapped"}, rd_data, m_out);
        else if (m_ok[opb[6:0]]) chk({req, "/R5 read array"}, rd_data, m_mem[opb[6:0]]);
        chk({req, "/R7 low digit"},  {1'b0, seg_lo_n}, {1'b0, exp_seg(m_out[3:0])});
        chk({req, "/R7 high digit"}, {1'b0, seg_hi_n}, {1'b0, exp_seg(m_out[7:4])});
    endtask

    // Drive one cycle, check the outputs before the edge, then update the model.
    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] b,
                        input string req);
        @(negedge clk);
        rf_we = we; opa = a; opb = b;
        #1 look(req);
        @(posedge clk);
        if (!we && rst_n) begin
            if (b[7]) m_out = a;
            else begin
                m_mem[b[6:0]] = a;
                m_ok[b[6:0]]  = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        for (int i = 0; i < 128; i++) m_ok[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        opb = 8'h80;
        #1;
        chk("R1 reset out reg", rd_data, 8'h00);
        chk("R1 reset low digit", {1'b0, seg_lo_n}, {1'b0, ~7'h3F});

        // Array ends and mapped ends (R2, R3).
        step(1'b0, 8'hA5, 8'h00, "R2 idx 0");
        step(1'b0, 8'h5A, 8'h7F, "R2 idx 7f");
        step(1'b0, 8'hC3, 8'h80, "R3 addr 80");
        step(1'b0, 8'h3C, 8'hFF, "R3 addr ff");
        step(1'b1, 8'h00, 8'h00, "R3 idx 0 untouched");
        step(1'b1, 8'h00, 8'h7F, "R3 idx 7f untouched");

        // Suppressed stores while the register file writes back (R4).
        step(1'b1, 8'h11, 8'h00, "R4 array");
        step(1'b1, 8'h22, 8'h80, "R4 out reg");
        step(1'b1, 8'h00, 8'h00, "R4 array readback");
        step(1'b1, 8'h00, 8'h80, "R4 out readback");

        // Sweep all nibbles on both digits (R8).
        for (int i = 0; i < 16; i++) begin
            step(1'b0, {i[3:0], 4'hF - i[3:0]}, 8'h80 | 8'(i), "R8 load");
            step(1'b1, 8'h00, 8'h80, "R8 show");
        end

        // Constrained random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic       we;
            logic [7:0] a;
            logic [7:0] b;
            we = ($urandom % 4) == 0;
            a  = 8'($urandom);
            b  = 8'($urandom);
            if (($urandom % 3) == 0) b[7] = 1'b1;
            else b[6:5] = 2'b00;
            step(we, a, b, "RND");
        end

        // Reset in mid-run clears the output register again (R1).
        step(1'b0, 8'hE7, 8'h80, "R1 preload");
        @(negedge clk);
        rst_n = 1'b0; rf_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_out = 8'h00;
        opb = 8'h80;
        #1;
        chk("R1 mid-run reset", rd_data, 8'h00);
        chk("R1 mid-run high digit", {1'b0, seg_hi_n}, {1'b0, ~7'h3F});

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule